// File: doc/BRIEF.md
# Parallel Word Parity Checker with Loss-of-Signal Squelch

This block sits on the 16-bit parallel side of a serial link transceiver. On the transmit side it takes a 16-bit data word and its parity bit every clock. It checks the 17 bits against a parity rule chosen at run time: odd or even. It drives a registered, active-high error level that is renewed every cycle.

On the receive side it registers the 16-bit word it is given and drives that word downstream. It also drives a parity bit equal to the XOR of the driven word. An optical module supplies a signal-detect line, which may be active high or active low. A polarity input states which sense applies. The signal-detect line passes through a synchronizer. A two-state machine then compares it with the polarity input. When the two disagree, the link counts as lost. The machine moves from `LINK_UP` to `SQUELCH` on that disagreement and returns to `LINK_UP` once the two agree again. While in `SQUELCH`, the received word is replaced by all zeros.

The whole block runs on one clock, the transmit parallel clock.

Top module: `lane_par_squelch`

## Requirements
- R1: With `par_even_sel` = 0, odd parity is expected. `par_err` is 1 after the clock edge that samples `tx_word`/`tx_par_in` when the 17 bits hold an even number of ones, and 0 otherwise.
- R2: With `par_even_sel` = 1, even parity is expected. `par_err` is 1 after the sampling edge when the 17 bits hold an odd number of ones, and 0 otherwise.
- R3: `par_err` is not sticky. The first good vector after a bad one returns it to 0 after its sampling edge.
- R4: In state `LINK_UP`, `rx_word_out` equals `rx_word_in` as sampled at the previous clock edge.
- R5: `rx_par_out` is always the XOR of the 16 bits of `rx_word_out`.
- R6: Loss of signal holds when `sd_in` differs from `sd_pol`. After `sd_in` changes into disagreement, `rx_word_out` keeps carrying data through the 3rd clock edge. It is all zeros from the 4th edge on. Transition `LINK_UP`->`SQUELCH` happens on the 3rd edge.
- R7: After `sd_in` returns to agreement with `sd_pol`, the `SQUELCH`->`LINK_UP` transition happens on the 3rd edge. `rx_word_out` carries data again from the 4th edge.
- R8: While squelched, `rx_par_out` is 0.
- R9: Synchronous active-high `rst` clears `par_err` to 0, `rx_word_out` to zeros, the synchronizer flops to 0, and the state to `LINK_UP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | 16 | Transmit data word |
| tx_par_in | input | 1 | Parity bit accompanying tx_word |
| par_even_sel | input | 1 | 0: odd parity expected, 1: even parity expected |
| par_err | output | 1 | Registered parity error level |
| rx_word_in | input | 16 | Received parallel word |
| sd_in | input | 1 | Asynchronous signal-detect from optics |
| sd_pol | input | 1 | Level of sd_in that means signal present |
| rx_word_out | output | 16 | Registered received word, zero while squelched |
| rx_par_out | output | 1 | XOR of rx_word_out bits |

## Verification
The parity error belongs to the vector sampled at the preceding edge. The bench drives a vector just after one edge and reads `par_err` just after the next. The same one-edge latency applies to `rx_word_out` while the link is up. `rx_par_out` is combinational on the registered word, so it is read together with it. Squelch on and off take two synchronizer edges, one state edge and one output edge. After each change of `sd_in`, the bench therefore confirms that data still passes after the third edge and that zeros, or restored data, appear after the fourth.

// File: rtl/lane_par_squelch_pkg.sv
package lane_par_squelch_pkg;
    typedef enum logic {
        LINK_UP = 1'b0,
        SQUELCH = 1'b1
    } los_state_e;
endpackage

// File: rtl/lps_par_chk.sv
module lps_par_chk #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              par_bit,
    input  logic              even_sel,
    output logic              err
);
    logic odd_ones;
    logic err_d;

    always_comb begin
        odd_ones = ^{word, par_bit};
        // odd expected (sel 0): error when count even; even expected: error when count odd
        err_d    = even_sel ? odd_ones : ~odd_ones;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= err_d;
    end

    // R1 / R2
    a_r1_r2_err_level: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err == ($past(even_sel) ? ($countones({$past(word), $past(par_bit)}) % 2 == 1)
                                           : ($countones({$past(word), $past(par_bit)}) % 2 == 0))));
    // R9
    a_r9_err_reset: assert property (@(posedge clk) rst |=> !err);
endmodule

// File: rtl/lps_sd_sync.sv
module lps_sd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lps_los_fsm.sv
module lps_los_fsm
    import lane_par_squelch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sd_sync,
    input  logic sd_pol,
    output logic squelch_en
);
    los_state_e state_q, state_d;
    logic       los;

    assign los = sd_sync ^ sd_pol;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_UP: if (los)  state_d = SQUELCH;
            SQUELCH: if (!los) state_d = LINK_UP;
            default:           state_d = LINK_UP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LINK_UP;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SQUELCH: squelch_en = 1'b1;
            default: squelch_en = 1'b0;
        endcase
    end

    // R6
    a_r6_enter_squelch: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINK_UP && (sd_sync != sd_pol)) |=> state_q == SQUELCH);
    // R7
    a_r7_leave_squelch: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQUELCH && (sd_sync == sd_pol)) |=> state_q == LINK_UP);
endmodule

// File: rtl/lane_par_squelch.sv
module lane_par_squelch #(
    parameter int WORD_W    = 16,
    parameter int SD_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_par_in,
    input  logic              par_even_sel,
    output logic              par_err,
    input  logic [WORD_W-1:0] rx_word_in,
    input  logic              sd_in,
    input  logic              sd_pol,
    output logic [WORD_W-1:0] rx_word_out,
    output logic              rx_par_out
);
    logic sd_s;
    logic squelch_en;

    lps_par_chk #(.WORD_W(WORD_W)) par_chk_i (
        .clk(clk), .rst(rst), .word(tx_word), .par_bit(tx_par_in),
        .even_sel(par_even_sel), .err(par_err)
    );

    lps_sd_sync #(.STAGES(SD_STAGES)) sd_sync_i (
        .clk(clk), .rst(rst), .async_in(sd_in), .sync_out(sd_s)
    );

    lps_los_fsm los_fsm_i (
        .clk(clk), .rst(rst), .sd_sync(sd_s), .sd_pol(sd_pol),
        .squelch_en(squelch_en)
    );

    always_ff @(posedge clk) begin
        if (rst)             rx_word_out <= '0;
        else if (squelch_en) rx_word_out <= '0;
        else                 rx_word_out <= rx_word_in;
    end

    assign rx_par_out = ^rx_word_out;

    // R6: squelch state yields zero output one edge later
    a_r6_zero_out: assert property (@(posedge clk) disable iff (rst)
        squelch_en |=> rx_word_out == '0);
    // R4
    a_r4_pass_through: assert property (@(posedge clk) disable iff (rst)
        !squelch_en |=> rx_word_out == $past(rx_word_in));
    // R8
    a_r8_par_zero: assert property (@(posedge clk) disable iff (rst)
        squelch_en |=> !rx_par_out);
    // R9
    a_r9_out_reset: assert property (@(posedge clk) rst |=> rx_word_out == '0);
endmodule

// File: tb/lane_par_squelch_tb_top.sv
module lane_par_squelch_tb_top;
    localparam int W = 16;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] tx_word = '0;
    logic tx_par_in = 1'b0;
    logic par_even_sel = 1'b0;
    logic par_err;
    logic [W-1:0] rx_word_in = '0;
    logic sd_in = 1'b1;
    logic sd_pol = 1'b1;
    logic [W-1:0] rx_word_out;
    logic rx_par_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lane_par_squelch dut_i (
        .clk(clk), .rst(rst), .tx_word(tx_word), .tx_par_in(tx_par_in),
        .par_even_sel(par_even_sel), .par_err(par_err),
        .rx_word_in(rx_word_in), .sd_in(sd_in), .sd_pol(sd_pol),
        .rx_word_out(rx_word_out), .rx_par_out(rx_par_out)
    );

    // {even_sel, par_bit, word, expected_err}
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0000, 1'b1},
        {1'b0, 1'b1, 16'h0000, 1'b0},
        {1'b1, 1'b0, 16'h0000, 1'b0},
        {1'b1, 1'b1, 16'h0000, 1'b1},
        {1'b0, 1'b0, 16'hFFFF, 1'b1},
        {1'b1, 1'b1, 16'hFFFF, 1'b1},
        {1'b0, 1'b0, 16'h0001, 1'b0},
        {1'b1, 1'b0, 16'h8001, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic exp_err(input logic sel, input logic p, input logic [W-1:0] w);
        int n;
        n = $countones({w, p});
        if (sel) return (n % 2) == 1;
        return (n % 2) == 0;
    endfunction

    function automatic logic xor16(input logic [W-1:0] w);
        logic r;
        r = 1'b0;
        for (int i = 0; i < W; i++) r = r ^ w[i];
        return r;
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w;
        rx_word_in = 16'hA5A5;
        tx_word = 16'h0000;
        tx_par_in = 1'b0;
        step();
        step();
        check("R9 err reset", {31'd0, par_err}, 32'd0);
        check("R9 rx reset", {16'd0, rx_word_out}, 32'd0);
        rst = 1'b0;

        // table walk, R1 R2
        for (int i = 0; i < NV; i++) begin
            par_even_sel = VEC[i][18];
            tx_par_in = VEC[i][17];
            tx_word = VEC[i][16:1];
            step();
            check(VEC[i][18] ? "R2 table" : "R1 table", {31'd0, par_err}, {31'd0, VEC[i][0]});
        end

        // R3: bad then good
        par_even_sel = 1'b0; tx_word = 16'h0003; tx_par_in = 1'b0;
        step();
        check("R3 bad", {31'd0, par_err}, 32'd1);
        tx_par_in = 1'b1;
        step();
        check("R3 clears", {31'd0, par_err}, 32'd0);

        // random vectors in both modes, with R4 R5 pass-through
        for (int i = 0; i < 200; i++) begin
            par_even_sel = i[0];
            tx_word = W'($urandom);
            tx_par_in = 1'($urandom);
            w = W'($urandom);
            rx_word_in = w;
            step();
            check(i[0] ? "R2 random" : "R1 random", {31'd0, par_err},
                  {31'd0, exp_err(par_even_sel, tx_par_in, tx_word)});
            check("R4 pass", {16'd0, rx_word_out}, {16'd0, w});
            check("R5 parity", {31'd0, rx_par_out}, {31'd0, xor16(w)});
        end

        // squelch for both polarities
        for (int pol = 0; pol < 2; pol++) begin
            sd_pol = pol[0];
            sd_in = pol[0];
            rx_word_in = 16'h1357;
            repeat (4) step();
            check("R4 link up", {16'd0, rx_word_out}, 32'h1357);
            sd_in = ~pol[0];
            step(); step(); step();
            check("R6 not yet", {16'd0, rx_word_out}, 32'h1357);
            step();
            check("R6 squelched", {16'd0, rx_word_out}, 32'd0);
            rx_word_in = 16'h0001;
            step();
            check("R8 par zero", {31'd0, rx_par_out}, 32'd0);
            check("R6 held", {16'd0, rx_word_out}, 32'd0);
            sd_in = pol[0];
            rx_word_in = 16'h00F1;
            step(); step(); step();
            check("R7 still zero", {16'd0, rx_word_out}, 32'd0);
            step();
            check("R7 restored", {16'd0, rx_word_out}, 32'h00F1);
            check("R5 restored par", {31'd0, rx_par_out}, 32'd1);
        end

        // reset mid-traffic
        par_even_sel = 1'b0; tx_word = 16'h0000; tx_par_in = 1'b0;
        step();
        check("R1 pre-reset", {31'd0, par_err}, 32'd1);
        rst = 1'b1;
        step();
        check("R9 err clear", {31'd0, par_err}, 32'd0);
        check("R9 rx clear", {16'd0, rx_word_out}, 32'd0);
        rst = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule